// File: doc/BRIEF.md
# Multi-FIFO Interprocessor Mailbox

This block is a memory-mapped mailbox that processors on one chip use to pass 32-bit messages to each other. It holds a set of small hardware FIFOs. A sender writes a word to a FIFO's message port. A receiver reads the same port to take the oldest word off the FIFO. Each FIFO also has a full flag and an occupancy count that any processor can read.

Several interrupt users share the block. Every user has its own status register, enable register, enable-clear register and interrupt line. Each FIFO drives two events into every user's status register: "a message arrived" and "space became free". The events are cleared by writing 1. A user's line is raised whenever one of its status bits is set and the matching enable bit is also set.

Access goes through a simple single-cycle bus. A write takes effect at the clock edge where it is presented. Read data appears on the registered output right after that edge.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset every FIFO is empty, every status and enable bit is 0 and every interrupt line is low.
- R2: A write to address 0x040+4·m pushes the write data into FIFO m. A read of that address removes and returns the oldest word. Read data of any register is valid on `bus_rdata` in the cycle after the read edge.
- R3: Address 0x0C0+4·m returns the exact number of words held in FIFO m. Address 0x080+4·m returns 1 when FIFO m holds DEPTH words and 0 otherwise.
- R4: A push to a full FIFO is dropped with no change to contents or count. A read of an empty FIFO's message port returns 0 and changes nothing.
- R5: Each accepted push sets bit 2·m (new message) in the status register of every user, at address 0x104+0x10·u. Each read that takes FIFO m from full to not full sets bit 2·m+1 (space freed) in every user.
- R6: Writing a status register clears each bit written as 1 and keeps each bit written as 0. A read in the next cycle already shows the cleared value.
- R7: A write to 0x108+0x10·u stores the value into user u's enable register, and that address reads it back. Writing 1s to 0x10C+0x10·u clears the matching enable bits. The clear address reads 0.
- R8: Interrupt line u is high in exactly the cycles where user u's status AND enable is nonzero, on the same edge that the registers change.
- R9: Address 0x000 reads the fixed revision parameter, and writes to it are ignored. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access strobe for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address, word aligned |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| irq | output | NUM_USER | One interrupt line per user |

## Verification
Damage to a FIFO pointer does not show at once. It appears as a wrong or repeated word on the next pop of that FIFO, and the count register exposes a wrong occupancy on its next read. A stray or missing status bit reaches the interrupt pins in the same cycle whenever the bit is enabled; when it is not enabled, it only appears on a status readback. A reference model with one queue per FIFO therefore compares the interrupt lines on every clock and every read value as it returns. It also runs a long pseudo-random access sequence, so that hidden state drift eventually reaches a pin.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  typedef enum logic [2:0] {
    RK_NONE, RK_REV, RK_MSG, RK_FULL, RK_CNT, RK_STAT, RK_EN, RK_CLR
  } reg_kind_e;

  localparam int OFS_MSG    = 'h040;
  localparam int OFS_FULL   = 'h080;
  localparam int OFS_CNT    = 'h0C0;
  localparam int OFS_USR    = 'h100;
  localparam int USR_STRIDE = 16;
  localparam int IDX_W      = 4;
endpackage

// File: rtl/mbox_fifo.sv
module mbox_fifo #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic              pop,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] head,
  output logic              full,
  output logic              empty,
  output logic [CNT_W-1:0]  count
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wptr, rptr;
  logic [CNT_W-1:0]  cnt;
  logic              push_ok, pop_ok;

  assign full    = (cnt == CNT_W'(DEPTH));
  assign empty   = (cnt == '0);
  assign push_ok = push & ~full;
  assign pop_ok  = pop & ~empty;
  assign head    = mem[rptr];
  assign count   = cnt;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (push_ok) wptr <= nxt(wptr);
      if (pop_ok)  rptr <= nxt(rptr);
      case ({push_ok, pop_ok})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(DEPTH)); // R3
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop) |=> $stable(cnt)); // R4
  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (rst)
    (pop && empty && !push) |=> $stable(cnt)); // R4
endmodule

// File: rtl/mbox_irq_user.sv
module mbox_irq_user #(
  parameter int EVW = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [EVW-1:0] evt,
  input  logic           wr_stat,
  input  logic           wr_en,
  input  logic           wr_clr,
  input  logic [EVW-1:0] wdata,
  output logic [EVW-1:0] stat,
  output logic [EVW-1:0] en,
  output logic           irq
);
  logic [EVW-1:0] stat_q, en_q, stat_nx, en_nx;
  logic           irq_q;

  always_comb begin
    stat_nx = (stat_q & ~(wr_stat ? wdata : '0)) | evt;
    if (wr_en)       en_nx = wdata;
    else if (wr_clr) en_nx = en_q & ~wdata;
    else             en_nx = en_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      en_q   <= '0;
      irq_q  <= 1'b0;
    end else begin
      stat_q <= stat_nx;
      en_q   <= en_nx;
      irq_q  <= |(stat_nx & en_nx);
    end
  end

  assign stat = stat_q;
  assign en   = en_q;
  assign irq  = irq_q;

  AST_EVT_SETS: assert property (@(posedge clk) disable iff (rst)
    (|evt) |=> ((stat_q & $past(evt)) == $past(evt))); // R5
  AST_W1C: assert property (@(posedge clk) disable iff (rst)
    (wr_stat && evt == '0) |=> ((stat_q & $past(wdata)) == '0)); // R6
  AST_EN_CLR: assert property (@(posedge clk) disable iff (rst)
    (wr_clr && !wr_en) |=> ((en_q & $past(wdata)) == '0)); // R7
  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (rst)
    irq_q == |(stat_q & en_q)); // R8
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
  import mbox_pkg::*;
#(
  parameter int NUM_FIFO   = 4,
  parameter int NUM_USER   = 2,
  parameter int FIFO_DEPTH = 4,
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 12,
  parameter logic [DATA_W-1:0] REV_VALUE = 'h0000_0100
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic [NUM_USER-1:0] irq
);
  localparam int EVW   = 2 * NUM_FIFO;
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);
  localparam logic [ADDR_W-1:0] A_MSG_LO  = ADDR_W'(OFS_MSG);
  localparam logic [ADDR_W-1:0] A_MSG_HI  = ADDR_W'(OFS_MSG + 4 * NUM_FIFO);
  localparam logic [ADDR_W-1:0] A_FULL_LO = ADDR_W'(OFS_FULL);
  localparam logic [ADDR_W-1:0] A_FULL_HI = ADDR_W'(OFS_FULL + 4 * NUM_FIFO);
  localparam logic [ADDR_W-1:0] A_CNT_LO  = ADDR_W'(OFS_CNT);
  localparam logic [ADDR_W-1:0] A_CNT_HI  = ADDR_W'(OFS_CNT + 4 * NUM_FIFO);
  localparam logic [ADDR_W-1:0] A_USR_LO  = ADDR_W'(OFS_USR);
  localparam logic [ADDR_W-1:0] A_USR_HI  = ADDR_W'(OFS_USR + USR_STRIDE * NUM_USER);

  reg_kind_e         kind;
  logic [IDX_W-1:0]  idx;
  logic [ADDR_W-1:0] usr_off;
  logic              wr_acc, rd_acc;

  always_comb begin
    kind    = RK_NONE;
    idx     = '0;
    usr_off = bus_addr - A_USR_LO;
    if (bus_addr[1:0] == 2'b00) begin
      if (bus_addr == '0) begin
        kind = RK_REV;
      end else if (bus_addr >= A_MSG_LO && bus_addr < A_MSG_HI) begin
        kind = RK_MSG;  idx = bus_addr[5:2];
      end else if (bus_addr >= A_FULL_LO && bus_addr < A_FULL_HI) begin
        kind = RK_FULL; idx = bus_addr[5:2];
      end else if (bus_addr >= A_CNT_LO && bus_addr < A_CNT_HI) begin
        kind = RK_CNT;  idx = bus_addr[5:2];
      end else if (bus_addr >= A_USR_LO && bus_addr < A_USR_HI) begin
        idx = usr_off[7:4];
        case (usr_off[3:2])
          2'd1:    kind = RK_STAT;
          2'd2:    kind = RK_EN;
          2'd3:    kind = RK_CLR;
          default: kind = RK_NONE;
        endcase
      end
    end
  end

  assign wr_acc = bus_sel & bus_wr;
  assign rd_acc = bus_sel & ~bus_wr;

  logic [DATA_W-1:0]   head_w [NUM_FIFO];
  logic [CNT_W-1:0]    cnt_w  [NUM_FIFO];
  logic [NUM_FIFO-1:0] full_w, empty_w, push_req, pop_req;
  logic [EVW-1:0]      evt;

  for (genvar m = 0; m < NUM_FIFO; m++) begin : g_fifo
    assign push_req[m] = wr_acc && kind == RK_MSG && idx == IDX_W'(m);
    assign pop_req[m]  = rd_acc && kind == RK_MSG && idx == IDX_W'(m);
    mbox_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk(clk), .rst(rst), .push(push_req[m]), .pop(pop_req[m]),
      .din(bus_wdata), .head(head_w[m]), .full(full_w[m]),
      .empty(empty_w[m]), .count(cnt_w[m]));
    assign evt[2*m]   = push_req[m] & ~full_w[m];
    assign evt[2*m+1] = pop_req[m] & full_w[m];
  end

  logic [EVW-1:0] stat_w [NUM_USER];
  logic [EVW-1:0] en_w   [NUM_USER];

  for (genvar u = 0; u < NUM_USER; u++) begin : g_user
    logic hit;
    assign hit = wr_acc && idx == IDX_W'(u);
    mbox_irq_user #(.EVW(EVW)) u_user (
      .clk(clk), .rst(rst), .evt(evt),
      .wr_stat(hit && kind == RK_STAT),
      .wr_en(hit && kind == RK_EN),
      .wr_clr(hit && kind == RK_CLR),
      .wdata(bus_wdata[EVW-1:0]),
      .stat(stat_w[u]), .en(en_w[u]), .irq(irq[u]));
  end

  logic [DATA_W-1:0] rmux, rdata_q;

  always_comb begin
    rmux = '0;
    case (kind)
      RK_REV: rmux = REV_VALUE;
      RK_MSG:
        for (int m = 0; m < NUM_FIFO; m++)
          if (idx == IDX_W'(m)) rmux = empty_w[m] ? '0 : head_w[m];
      RK_FULL:
        for (int m = 0; m < NUM_FIFO; m++)
          if (idx == IDX_W'(m)) rmux = DATA_W'(full_w[m]);
      RK_CNT:
        for (int m = 0; m < NUM_FIFO; m++)
          if (idx == IDX_W'(m)) rmux = DATA_W'(cnt_w[m]);
      RK_STAT:
        for (int u = 0; u < NUM_USER; u++)
          if (idx == IDX_W'(u)) rmux = DATA_W'(stat_w[u]);
      RK_EN:
        for (int u = 0; u < NUM_USER; u++)
          if (idx == IDX_W'(u)) rmux = DATA_W'(en_w[u]);
      default: rmux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= '0;
    else if (rd_acc) rdata_q <= rmux;
    else             rdata_q <= '0;
  end

  assign bus_rdata = rdata_q;

  AST_REV_READ: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && !bus_wr && bus_addr == '0) |=> (bus_rdata == REV_VALUE)); // R9
endmodule

// File: tb/ipc_mailbox_test.sv
`timescale 1ns/1ps
module ipc_mailbox_test;
  localparam int NF = 4, NU = 2, DEPTH = 4;
  localparam logic [31:0] REV = 32'h0000_0100;

  logic        clk = 1'b0, rst = 1'b1;
  logic        sel = 1'b0, wr_s = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] bus_rdata;
  logic [NU-1:0] irq;

  always #2.5 clk = ~clk;

  ipc_mailbox uut (
    .clk(clk), .rst(rst), .bus_sel(sel), .bus_wr(wr_s), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(bus_rdata), .irq(irq));

  int total = 0, bad = 0;
  bit done = 0;

  logic [31:0] q [NF][$];
  logic [7:0]  st [NU];
  logic [7:0]  en [NU];

  task automatic check(input logic [31:0] got, input logic [31:0] exp, input string tag);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic check_irq();
    for (int u = 0; u < NU; u++)
      check(32'(irq[u]), 32'(|(st[u] & en[u])), "R8 irq line");
  endtask

  task automatic model_op(input bit wr, input int a, input logic [31:0] d,
                          output logic [31:0] e);
    e = '0;
    if (a >= 'h40 && a < 'h40 + 4*NF) begin
      int m = (a - 'h40) / 4;
      if (wr) begin
        if (q[m].size() < DEPTH) begin
          q[m].push_back(d);
          for (int u = 0; u < NU; u++) st[u][2*m] = 1'b1;
        end
      end else if (q[m].size() > 0) begin
        bit was_full = (q[m].size() == DEPTH);
        e = q[m].pop_front();
        if (was_full) for (int u = 0; u < NU; u++) st[u][2*m+1] = 1'b1;
      end
    end else if (a >= 'h80 && a < 'h80 + 4*NF) begin
      e = (q[(a - 'h80) / 4].size() == DEPTH) ? 32'd1 : 32'd0;
    end else if (a >= 'hC0 && a < 'hC0 + 4*NF) begin
      e = 32'(q[(a - 'hC0) / 4].size());
    end else if (a >= 'h100 && a < 'h100 + 16*NU) begin
      int u = (a - 'h100) / 16;
      int s = (a - 'h100) % 16;
      if (s == 4) begin
        if (wr) st[u] = st[u] & ~d[7:0]; else e = 32'(st[u]);
      end else if (s == 8) begin
        if (wr) en[u] = d[7:0]; else e = 32'(en[u]);
      end else if (s == 12) begin
        if (wr) en[u] = en[u] & ~d[7:0];
      end
    end else if (a == 0 && !wr) begin
      e = REV;
    end
  endtask

  task automatic op(input bit wr, input int a, input logic [31:0] d, input string tag);
    logic [31:0] e;
    @(negedge clk);
    sel = 1'b1; wr_s = wr; addr = 12'(a); wdata = d;
    @(posedge clk); #1;
    model_op(wr, a, d, e);
    if (!wr) check(bus_rdata, e, tag);
    check_irq();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); sel = 1'b0; wr_s = 1'b0;
      @(posedge clk); #1;
      check_irq();
    end
  endtask

  initial begin
    for (int u = 0; u < NU; u++) begin st[u] = '0; en[u] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    check(32'(irq), 32'd0, "R1 irq after reset");
    op(0, 'hC0, 0, "R1 count empty");
    op(0, 'h80, 0, "R1 full flag");
    op(0, 'h104, 0, "R1 status");
    op(0, 'h118, 0, "R1 enable");

    op(0, 'h000, 0, "R9 revision");
    check(bus_rdata, REV, "R9 revision constant");
    op(1, 'h000, 32'hDEAD_BEEF, "R9 write");
    op(0, 'h000, 0, "R9 revision after write");
    op(0, 'h03C, 0, "R9 unmapped");
    op(0, 'h100, 0, "R9 unmapped user slot");

    op(1, 'h40, 32'h1111_0001, "R2");
    op(1, 'h40, 32'h1111_0002, "R2");
    op(1, 'h40, 32'h1111_0003, "R2");
    op(0, 'hC0, 0, "R3 count three");
    check(bus_rdata, 32'd3, "R3 count literal");
    op(0, 'h104, 0, "R5 new-message user0");
    op(0, 'h114, 0, "R5 new-message user1");
    check(bus_rdata, 32'h1, "R5 bit0 set");
    op(1, 'h108, 32'h1, "R7 enable write");
    op(0, 'h108, 0, "R7 enable readback");
    op(0, 'h40, 0, "R2 pop first");
    check(bus_rdata, 32'h1111_0001, "R2 oldest first");
    op(0, 'h40, 0, "R2 pop second");
    op(0, 'h40, 0, "R2 pop third");
    op(0, 'h40, 0, "R4 pop empty");
    check(bus_rdata, 32'd0, "R4 empty returns zero");
    op(0, 'hC0, 0, "R4 count unchanged");

    for (int i = 0; i < 5; i++) op(1, 'h44, 32'hA000 + i, "R4 fill");
    op(0, 'h84, 0, "R3 full flag set");
    check(bus_rdata, 32'd1, "R3 full literal");
    op(0, 'hC4, 0, "R4 count at depth");
    op(0, 'h44, 0, "R2 pop from full");
    op(0, 'h104, 0, "R5 not-full event");
    check(bus_rdata & 32'h8, 32'h8, "R5 bit3 set");
    op(0, 'h84, 0, "R3 full flag clear");
    for (int i = 0; i < 4; i++) op(0, 'h44, 0, "R4 dropped word absent");

    op(1, 'h104, 32'h0, "R6 write zero");
    op(0, 'h104, 0, "R6 unchanged");
    op(1, 'h104, 32'h1, "R6 clear bit0");
    op(0, 'h104, 0, "R6 cleared readback");
    check(bus_rdata & 32'h1, 32'h0, "R6 bit0 clear");
    idle(2);

    op(1, 'h118, 32'hFF, "R7 enable user1");
    op(1, 'h11C, 32'h0F, "R7 clear low bits");
    op(0, 'h118, 0, "R7 after clear");
    check(bus_rdata, 32'hF0, "R7 literal");
    op(0, 'h11C, 0, "R7 clear reads zero");
    op(1, 'h4C, 32'h3333_0001, "R5 fifo3 push");
    op(0, 'h114, 0, "R5 fifo3 event user1");
    op(1, 'h118, 32'h40, "R8 enable fifo3 bit");
    idle(2);
    op(1, 'h114, 32'hFF, "R8 drop by clear");
    idle(2);

    begin
      logic [31:0] lf = 32'h1ACE_B00C;
      for (int i = 0; i < 600; i++) begin
        int k, m, u, a;
        lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
        k = int'(lf[2:0]); if (k == 7) k = 1;
        m = int'(lf[4:3]); u = int'(lf[5]);
        case (k)
          0: a = 0;
          1: a = 'h40 + 4*m;
          2: a = 'h80 + 4*m;
          3: a = 'hC0 + 4*m;
          4: a = 'h104 + 16*u;
          5: a = 'h108 + 16*u;
          default: a = 'h10C + 16*u;
        endcase
        op(lf[9] | (k == 1 && lf[10]), a, {lf[15:0], lf[31:16]}, "R2 random traffic");
      end
    end
    idle(2);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R1 watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule